// File: doc/BRIEF.md
# Register-List Stack Frame Sequencer

This block carries out the memory side of a subroutine frame in a processor pipeline. It saves any subset of the twelve callee-saved registers r20 to r31 to a downward-growing stack and reserves local space. It can also do the reverse: drop the local space, reload the saved subset and, if asked, hand back a branch target read from a register. A single start strobe launches one operation. The block then works on its own through the register-file port and a word-wide memory port, one word per handshake.

The caller supplies the operation kind, a 12-bit selection mask, a 5-bit local-frame size in words, an optional target-register index and the current stack pointer. At the end the block presents the new stack pointer for one cycle, together with a completion pulse. A teardown that names a target register also gives one branch-target pulse before completion. Instruction decode, caching and the register file itself sit outside the block.

Top module: `fsq_frame_seq`

## Requirements
- R1: While reset is asserted, and after it is released until a start is accepted, busy_o, done_o, sp_we_o, mem_req_o, rf_we_o and jump_valid_o are all low.
- R2: The selection mask is 12 bits wide; bit k set selects register r(20+k), and only selected registers are transferred, one memory access each.
- R3: A setup (op_i = 0) stores the selected registers with lower-numbered registers at higher addresses. With SP the stack pointer at start, the j-th selected register in ascending register order (j from 0) goes to word address SP - 4*(j+1).
- R4: After its stores, a setup further lowers the stack pointer by 4 times the frame size, so the final stack pointer equals SP - 4*(count + frame).
- R5: A teardown (op_i = 1) first raises the stack pointer by 4 times the frame size. It then loads the selected registers, highest-numbered first, each from the current stack pointer followed by a 4-byte increment. The final stack pointer equals SP + 4*(frame + count).
- R6: A teardown whose target index is nonzero raises jump_valid_o for exactly one cycle, with jump_target_o equal to that register's contents after all reloads. A zero index gives no branch pulse, and a setup never gives one.
- R7: A memory request is held, with address, write enable and write data unchanged, until the acknowledge; the next access starts only after it.
- R8: An empty mask makes no memory access; the operation only adjusts the stack pointer by the frame size.
- R9: done_o and sp_we_o are high together for exactly one cycle, with sp_o showing the final stack pointer. busy_o is high from the cycle after an accepted start through the done cycle, and a start seen while busy is ignored.
- R10: Memory writes occur only in setup and register-file writes only in teardown; every access is one 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch strobe, accepted when idle |
| op_i | input | 1 | 0 = setup, 1 = teardown |
| list_i | input | 12 | Register selection mask, bit k = r(20+k) |
| frame_i | input | 5 | Local frame size in words |
| jreg_i | input | 5 | Teardown branch register index, 0 = none |
| sp_i | input | 32 | Stack pointer at start |
| rf_addr_o | output | 5 | Register-file index for read and write |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| sp_o | output | 32 | Final stack pointer |
| sp_we_o | output | 1 | Stack pointer write-back strobe |
| jump_valid_o | output | 1 | Branch target valid pulse |
| jump_target_o | output | 32 | Branch target |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |

## Verification
The hardest case to reach from the ports is a teardown that branches through a register it has just reloaded. The target must reflect the value restored from the stack, not the one held before. This can only be seen when a matching setup wrote known data beforehand. The stimulus therefore runs setup and teardown in pairs, with the register file scrambled between them and random acknowledge delays. A directed case selects r31 as both a saved register and the branch register. A second hard case is a new strobe arriving mid-operation. A directed run raises a conflicting start while a store is pending and checks that the count of transfers and the final pointer match the first request alone.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RELEASE,
    ST_SCAN,
    ST_XFER,
    ST_ALLOC,
    ST_JUMP,
    ST_FINISH
  } fsq_state_e;

  typedef enum logic {
    OP_SETUP    = 1'b0,
    OP_TEARDOWN = 1'b1
  } fsq_op_e;
endpackage

// File: rtl/fsq_rst_sync.sv
`timescale 1ns/1ps
module fsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/fsq_pick.sv
`timescale 1ns/1ps
module fsq_pick #(
  parameter int N  = 12,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  input  logic          high_first_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [IW-1:0] lo_idx;
  logic [IW-1:0] hi_idx;

  // lowest set bit: scan downward so the last hit wins
  always_comb begin
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) lo_idx = IW'(i);
    end
  end

  // highest set bit: scan upward so the last hit wins
  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i]) hi_idx = IW'(i);
    end
  end

  assign any_o = |mask_i;
  assign idx_o = high_first_i ? hi_idx : lo_idx;
endmodule

// File: rtl/fsq_ctrl.sv
`timescale 1ns/1ps
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int N        = 12,
  parameter int BASE_REG = 20,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int FW       = 5,
  parameter int RIDX     = 5,
  localparam int IW      = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            op_i,
  input  logic [N-1:0]    list_i,
  input  logic [FW-1:0]   frame_i,
  input  logic [RIDX-1:0] jreg_i,
  input  logic [AW-1:0]   sp_i,
  output logic [N-1:0]    pick_mask_o,
  output logic            pick_high_o,
  input  logic [IW-1:0]   pick_idx_i,
  input  logic            pick_any_i,
  output logic [RIDX-1:0] rf_addr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  output logic [AW-1:0]   sp_o,
  output logic            sp_we_o,
  output logic            jump_valid_o,
  output logic [DW-1:0]   jump_target_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  fsq_state_e      state_q, state_d;
  fsq_op_e         op_q;
  logic [N-1:0]    pend_q, pend_d;
  logic [FW-1:0]   frame_q;
  logic [RIDX-1:0] jreg_q;
  logic [AW-1:0]   sp_q, sp_d;
  logic [IW-1:0]   cur_q, cur_d;
  logic            latch_en;
  logic [AW-1:0]   frame_bytes;
  logic [RIDX-1:0] slot_reg;

  assign frame_bytes = {{(AW-FW-2){1'b0}}, frame_q, 2'b00};
  assign slot_reg    = RIDX'(BASE_REG) + RIDX'(cur_q);

  // next-state and datapath
  always_comb begin
    state_d  = state_q;
    sp_d     = sp_q;
    pend_d   = pend_q;
    cur_d    = cur_q;
    latch_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          latch_en = 1'b1;
          sp_d     = sp_i;
          pend_d   = list_i;
          state_d  = op_i ? ST_RELEASE : ST_SCAN;
        end
      end
      ST_RELEASE: begin
        sp_d    = sp_q + frame_bytes;
        state_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (pick_any_i) begin
          cur_d = pick_idx_i;
          if (op_q == OP_SETUP) sp_d = sp_q - WORD_BYTES;
          state_d = ST_XFER;
        end else if (op_q == OP_SETUP) begin
          state_d = ST_ALLOC;
        end else if (jreg_q != '0) begin
          state_d = ST_JUMP;
        end else begin
          state_d = ST_FINISH;
        end
      end
      ST_XFER: begin
        if (mem_ack_i) begin
          pend_d[cur_q] = 1'b0;
          if (op_q == OP_TEARDOWN) sp_d = sp_q + WORD_BYTES;
          state_d = ST_SCAN;
        end
      end
      ST_ALLOC: begin
        sp_d    = sp_q - frame_bytes;
        state_d = ST_FINISH;
      end
      ST_JUMP:   state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      pend_q  <= '0;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      pend_q  <= pend_d;
      cur_q   <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_SETUP;
      frame_q <= '0;
      jreg_q  <= '0;
    end else if (latch_en) begin
      op_q    <= fsq_op_e'(op_i);
      frame_q <= frame_i;
      jreg_q  <= jreg_i;
    end
  end

  // outputs
  assign pick_mask_o   = pend_q;
  assign pick_high_o   = (op_q == OP_TEARDOWN);
  assign rf_addr_o     = (state_q == ST_JUMP) ? jreg_q : slot_reg;
  assign rf_we_o       = (state_q == ST_XFER) && mem_ack_i && (op_q == OP_TEARDOWN);
  assign rf_wdata_o    = mem_rdata_i;
  assign mem_req_o     = (state_q == ST_XFER);
  assign mem_we_o      = mem_req_o && (op_q == OP_SETUP);
  assign mem_addr_o    = sp_q;
  assign mem_wdata_o   = rf_rdata_i;
  assign jump_valid_o  = (state_q == ST_JUMP);
  assign jump_target_o = jump_valid_o ? rf_rdata_i : '0;
  assign done_o        = (state_q == ST_FINISH);
  assign sp_we_o       = done_o;
  assign sp_o          = sp_q;
  assign busy_o        = (state_q != ST_IDLE);

  // checks next to the logic they guard
  assert_pick_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && pick_any_i) |-> pend_q[pick_idx_i])
    else $error("pick points at a slot that is not pending");

  assert_store_predec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && pick_any_i && op_q == OP_SETUP) |=> (sp_q == $past(sp_q) - WORD_BYTES))
    else $error("setup store address not pre-decremented");

  assert_jump_only_teardown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid_o |-> (jreg_q != '0 && op_q == OP_TEARDOWN))
    else $error("branch pulse without a teardown target");

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(rf_addr_o)))
    else $error("memory request dropped or changed before acknowledge");

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(frame_q) && $stable(jreg_q)))
    else $error("start accepted while busy");
endmodule

// File: rtl/fsq_frame_seq.sv
`timescale 1ns/1ps
module fsq_frame_seq #(
  parameter int N        = 12,
  parameter int BASE_REG = 20,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int FW       = 5,
  parameter int RIDX     = 5
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            start_i,
  input  logic            op_i,
  input  logic [N-1:0]    list_i,
  input  logic [FW-1:0]   frame_i,
  input  logic [RIDX-1:0] jreg_i,
  input  logic [AW-1:0]   sp_i,
  output logic [RIDX-1:0] rf_addr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  output logic [AW-1:0]   sp_o,
  output logic            sp_we_o,
  output logic            jump_valid_o,
  output logic [DW-1:0]   jump_target_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int IW = $clog2(N);

  logic          rst_n;
  logic [N-1:0]  pick_mask;
  logic          pick_high;
  logic [IW-1:0] pick_idx;
  logic          pick_any;

  fsq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  fsq_pick #(.N(N)) u_pick (
    .mask_i       (pick_mask),
    .high_first_i (pick_high),
    .idx_o        (pick_idx),
    .any_o        (pick_any)
  );

  fsq_ctrl #(
    .N(N), .BASE_REG(BASE_REG), .AW(AW), .DW(DW), .FW(FW), .RIDX(RIDX)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .op_i          (op_i),
    .list_i        (list_i),
    .frame_i       (frame_i),
    .jreg_i        (jreg_i),
    .sp_i          (sp_i),
    .pick_mask_o   (pick_mask),
    .pick_high_o   (pick_high),
    .pick_idx_i    (pick_idx),
    .pick_any_i    (pick_any),
    .rf_addr_o     (rf_addr_o),
    .rf_rdata_i    (rf_rdata_i),
    .rf_we_o       (rf_we_o),
    .rf_wdata_o    (rf_wdata_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_rdata_i   (mem_rdata_i),
    .mem_ack_i     (mem_ack_i),
    .sp_o          (sp_o),
    .sp_we_o       (sp_we_o),
    .jump_valid_o  (jump_valid_o),
    .jump_target_o (jump_target_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );
endmodule

// File: tb/sim_fsq_frame_seq.sv
`timescale 1ns/1ps
module sim_fsq_frame_seq;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        arst_n;
  logic        start;
  logic        op;
  logic [11:0] list;
  logic [4:0]  frame;
  logic [4:0]  jreg;
  logic [31:0] sp_in;
  logic [4:0]  rf_addr;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [31:0] rf_wdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] sp_out, jt;
  logic        sp_we, jv, busy, done;

  fsq_frame_seq u0 (
    .clk(clk), .arst_n(arst_n), .start_i(start), .op_i(op), .list_i(list),
    .frame_i(frame), .jreg_i(jreg), .sp_i(sp_in),
    .rf_addr_o(rf_addr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .sp_o(sp_out), .sp_we_o(sp_we), .jump_valid_o(jv), .jump_target_o(jt),
    .busy_o(busy), .done_o(done)
  );

  // register file and memory models (sole writers of their arrays)
  logic [31:0] rf  [32];
  logic [31:0] mem [256];
  logic        scr_rf, scr_mem;
  int          dly;

  assign rf_rdata = (rf_addr == 5'd0) ? 32'd0 : rf[rf_addr];

  always @(posedge clk) begin
    if (scr_rf)  for (int i = 0; i < 32; i++)  rf[i]  <= $urandom;
    if (scr_mem) for (int i = 0; i < 256; i++) mem[i] <= $urandom;
    if (rf_we && rf_addr != 5'd0) rf[rf_addr] <= rf_wdata;
    if (!arst_n) begin
      mem_ack <= 1'b0;
      dly     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (dly == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        dly <= int'($urandom_range(0, 3));
      end else begin
        dly <= dly - 1;
      end
    end
  end

  // monitor, sampled away from the active edge
  logic        mon_clr;
  logic        cur_op;
  int          xfers, jumps, dones, bad_dir, done_wide;
  logic [31:0] got_sp, got_tgt;
  logic        prev_done;

  always @(negedge clk) begin
    if (mon_clr) begin
      xfers = 0; jumps = 0; dones = 0; bad_dir = 0; done_wide = 0;
      got_sp = '0; got_tgt = '0; prev_done = 1'b0;
    end else begin
      if (mem_req && mem_ack) xfers++;
      if (mem_req && (mem_we != (cur_op == 1'b0))) bad_dir++;
      if (rf_we && cur_op == 1'b0) bad_dir++;
      if (jv) begin jumps++; got_tgt = jt; end
      if (done) begin
        dones++;
        got_sp = sp_out;
        if (!sp_we || !busy) done_wide++;
        if (prev_done) done_wide++;
      end
      prev_done = done;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [11:0] l);
    int c = 0;
    for (int i = 0; i < 12; i++) if (l[i]) c++;
    return c;
  endfunction

  function automatic logic [31:0] exp_sp(input logic o, input logic [31:0] s,
                                         input logic [11:0] l, input logic [4:0] f);
    logic [31:0] d = 32'(4 * (popc(l) + int'(f)));
    return o ? s + d : s - d;
  endfunction

  logic [31:0] snap [32];

  task automatic take_snap();
    for (int i = 0; i < 32; i++) snap[i] = rf[i];
  endtask

  task automatic scramble_rf();
    @(negedge clk); scr_rf = 1'b1;
    @(negedge clk); scr_rf = 1'b0;
  endtask

  // run one operation; optionally raise a conflicting start while busy
  task automatic run_op(input logic o, input logic [11:0] l, input logic [4:0] f,
                        input logic [4:0] j, input logic [31:0] s, input bit inject);
    int guard;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    cur_op = o; op = o; list = l; frame = f; jreg = j; sp_in = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", 32'(busy), 32'd1);
    if (inject) begin
      @(negedge clk);
      op = ~o; list = 12'hFFF; frame = 5'd31; jreg = 5'd7; sp_in = 32'h0; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (dones == 0 && guard < 3000) begin
      @(posedge clk);
      guard++;
    end
    if (dones == 0) check(1'b0, "R9", "operation timed out", 32'd0, 32'd1);
    @(negedge clk);
    check(done_wide == 0, "R9", "done/sp_we single-cycle", 32'(done_wide), 32'd0);
    check(bad_dir == 0, "R10", "access direction", 32'(bad_dir), 32'd0);
    check(xfers == popc(l), "R2", "transfer count", 32'(xfers), 32'(popc(l)));
    check(got_sp == exp_sp(o, s, l, f), o ? "R5" : "R4", "final sp",
          got_sp, exp_sp(o, s, l, f));
  endtask

  task automatic check_setup_layout(input logic [11:0] l, input logic [31:0] s);
    int jj = 0;
    bit ok = 1'b1;
    logic [31:0] a, e;
    a = '0; e = '0;
    for (int k = 0; k < 12; k++) begin
      if (l[k]) begin
        logic [31:0] adr = s - 32'(4 * (jj + 1));
        if (mem[adr[9:2]] !== snap[20 + k] && ok) begin
          ok = 1'b0; a = mem[adr[9:2]]; e = snap[20 + k];
        end
        jj++;
      end
    end
    check(ok, "R3", "stored layout", a, e);
  endtask

  task automatic check_restore(input logic [11:0] l);
    bit ok = 1'b1;
    logic [31:0] a, e;
    a = '0; e = '0;
    for (int k = 0; k < 12; k++) begin
      if (l[k] && rf[20 + k] !== snap[20 + k] && ok) begin
        ok = 1'b0; a = rf[20 + k]; e = snap[20 + k];
      end
    end
    check(ok, "R5", "reloaded registers", a, e);
  endtask

  task automatic check_jump(input logic [4:0] j);
    if (j == 5'd0) begin
      check(jumps == 0, "R6", "no branch for zero index", 32'(jumps), 32'd0);
    end else begin
      check(jumps == 1, "R6", "branch pulse count", 32'(jumps), 32'd1);
      check(got_tgt == rf[j], "R6", "branch target", got_tgt, rf[j]);
    end
  endtask

  // setup then teardown with a scrambled register file in between
  task automatic pair(input logic [11:0] l, input logic [4:0] f, input logic [4:0] j,
                      input logic [31:0] s);
    logic [31:0] mid;
    take_snap();
    run_op(1'b0, l, f, 5'd0, s, 1'b0);
    check(jumps == 0, "R6", "no branch in setup", 32'(jumps), 32'd0);
    check_setup_layout(l, s);
    mid = exp_sp(1'b0, s, l, f);
    scramble_rf();
    run_op(1'b1, l, f, j, mid, 1'b0);
    check_restore(l);
    check_jump(j);
  endtask

  initial begin
    void'($urandom(32'd12345));
    arst_n = 1'b0; start = 1'b0; op = 1'b0; list = '0; frame = '0; jreg = '0;
    sp_in = '0; scr_rf = 1'b0; scr_mem = 1'b0; mon_clr = 1'b1; cur_op = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    check({busy, done, sp_we, mem_req, rf_we, jv} == 6'b0, "R1", "outputs in reset",
          32'({busy, done, sp_we, mem_req, rf_we, jv}), 32'd0);
    scr_rf = 1'b1; scr_mem = 1'b1;
    @(negedge clk); scr_rf = 1'b0; scr_mem = 1'b0;
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, done, sp_we, mem_req, rf_we, jv} == 6'b0, "R1", "outputs after release",
          32'({busy, done, sp_we, mem_req, rf_we, jv}), 32'd0);

    // R2/R3: single register r20, no frame
    pair(12'h001, 5'd0, 5'd0, 32'h0000_0300);
    // R3/R4/R5: full mask, largest frame
    pair(12'hFFF, 5'd31, 5'd0, 32'h0000_0300);
    // R8: empty mask, setup and teardown only move the pointer
    take_snap();
    run_op(1'b0, 12'h000, 5'd5, 5'd0, 32'h0000_0280, 1'b0);
    run_op(1'b1, 12'h000, 5'd5, 5'd0, 32'h0000_0280, 1'b0);
    check(xfers == 0, "R8", "no access on empty mask", 32'(xfers), 32'd0);
    check_jump(5'd0);
    // R6: branch through a register that was just reloaded (r31)
    pair(12'h801, 5'd3, 5'd31, 32'h0000_0300);
    check(got_tgt == snap[31], "R6", "target is restored r31", got_tgt, snap[31]);
    // R6: branch register outside the saved set
    pair(12'h0A0, 5'd1, 5'd4, 32'h0000_0300);
    // R9: conflicting start while busy is ignored
    take_snap();
    run_op(1'b0, 12'h0F0, 5'd2, 5'd0, 32'h0000_0300, 1'b1);
    check_setup_layout(12'h0F0, 32'h0000_0300);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R9", "idle after ignored start", 32'(busy), 32'd0);

    // constrained random pairs
    for (int it = 0; it < 30; it++) begin
      logic [11:0] rl = 12'($urandom);
      logic [4:0]  rfm = 5'($urandom);
      logic [4:0]  rj = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      logic [31:0] rs = 32'h0000_0200 + 32'(4 * $urandom_range(0, 64));
      pair(rl, rfm, rj, rs);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule